// File: doc/BRIEF.md
# DTMF Burst Tone Synthesizer

This block turns a 4-bit keypad code into a digital dual-tone sample stream. The code picks one of four low-group (row) tones and one of four high-group (column) tones. Each tone comes from its own oscillator. In each oscillator, a segment counter divides the system clock, and every time it expires it moves a 5-bit phase through a 32-step sine table. The two samples are added together with the column tone raised by about 2 dB. The result is registered and driven out as a signed 10-bit word, which feeds an external D/A converter and filter.

The block has two ways of timing its output:

- **Continuous mode.** The tone sounds for as long as the tone enable is high.
- **Burst mode.** Each accepted code write produces one fixed-length tone followed by a silent gap of the same length. When the gap ends, a ready flag rises. Both lengths double when call-progress timing is selected.

In single-tone mode only the row tone or only the column tone is emitted.

Top module: `dtmf_burst_gen`

## Requirements
- R1: The code selects the tone pair as (code: row, column), with rows 0..3 = 697, 770, 852, 941 Hz and columns 0..3 = 1209, 1336, 1477, 1633 Hz:
  - 1: 0,0; 2: 0,1; 3: 0,2
  - 4: 1,0; 5: 1,1; 6: 1,2
  - 7: 2,0; 8: 2,1; 9: 2,2
  - 10: 3,1; 11: 3,0; 12: 3,2
  - 13: 0,3; 14: 1,3; 15: 2,3
  - 0: 3,3
- R2: The segment length of each tone is CLK_HZ / (32 × f), rounded to the nearest integer.
- R3: Once a tone starts, the phase index of each oscillator holds for one segment length and then advances by one, wrapping after 32 steps. After clock edge k of running (k ≥ 1), sample_o reflects phase ((k−1) div seg_len) mod 32.
- R4: The sine value at phase p is round(127 × sin(2πp/32)), a signed 8-bit value.
- R5: In dual-tone mode, sample_o = row + col + floor(col/4). The result is two's complement and always lies within ±286.
- R6: With single_i = 1, sample_o = col + floor(col/4) when col_sel_i = 1, and sample_o = row when col_sel_i = 0.
- R7: When tone_en_i is low, the transmitter returns to idle. sample_o is 0 from the second clock edge after tone_en_i falls, and ready_o clears.
- R8: With burst_en_i low and tone_en_i high, the tone runs continuously from the clock edge after tone_en_i rises, and ready_o stays 0.
- R9: In burst mode, a write accepted while idle and enabled starts a tone of BURST_MS × TICK_DIV clock cycles. A silent pause of equal length follows.
- R10: With cp_mode_i = 1, both the burst and the pause last 2 × BURST_MS milliseconds.
- R11: ready_o rises on the clock edge that ends the pause. An accepted write clears it.
- R12: In burst mode, a write that arrives while a burst or pause is in progress is ignored. The running tone keeps the code that started it.
- R13: While reset is held, and directly after it, sample_o = 0 and ready_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock at CLK_HZ |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | One-cycle code write strobe |
| code_i | input | 4 | Keypad code |
| tone_en_i | input | 1 | Transmitter enable |
| burst_en_i | input | 1 | 1 selects burst timing, 0 selects continuous tone |
| cp_mode_i | input | 1 | Doubles the burst and pause lengths |
| single_i | input | 1 | Emit one tone only |
| col_sel_i | input | 1 | In single mode, 1 selects the column tone and 0 the row tone |
| sample_o | output | 10 | Signed tone sample |
| ready_o | output | 1 | Burst finished, ready for the next code |

## Verification
Every internal state shows up directly in the sample stream:

- **Wrong segment length, phase step or table value.** sample_o departs from the computed waveform within one segment, which is fewer than 50 cycles in the small configuration. The bench therefore compares every cycle of at least one full row-tone period for all sixteen codes.
- **Wrong burst counter.** The edge where the tone stops, or the edge where ready_o rises, lands on the wrong cycle. Both edges are checked to the exact cycle in both timing modes.
- **Wrongly latched code.** A write that should have been ignored changes the waveform in the very next segment.

// File: rtl/dtmf_pkg.sv
package dtmf_pkg;
  localparam int PH_W  = 5;
  localparam int SMP_W = 8;
  localparam int OUT_W = 10;
  localparam int ROW_HZ [4] = '{697, 770, 852, 941};
  localparam int COL_HZ [4] = '{1209, 1336, 1477, 1633};

  typedef logic [1:0] grp_idx_t;
  typedef enum logic [1:0] {ST_IDLE, ST_TONE, ST_PAUSE} tx_state_e;

  // nearest-integer segment length for 32 segments per period
  function automatic int seg_len(input int clk_hz, input int f_hz);
    return (clk_hz + 16 * f_hz) / (32 * f_hz);
  endfunction

  // quarter-wave table mirrored over the full period
  function automatic logic signed [SMP_W-1:0] sine_at(input logic [PH_W-1:0] ph);
    logic [3:0] idx;
    logic [6:0] mag;
    logic signed [SMP_W-1:0] m;
    idx = ph[3] ? (4'd8 - {1'b0, ph[2:0]}) : {1'b0, ph[2:0]};
    case (idx)
      4'd0: mag = 7'd0;
      4'd1: mag = 7'd25;
      4'd2: mag = 7'd49;
      4'd3: mag = 7'd71;
      4'd4: mag = 7'd90;
      4'd5: mag = 7'd106;
      4'd6: mag = 7'd117;
      4'd7: mag = 7'd125;
      4'd8: mag = 7'd127;
      default: mag = 7'd0;
    endcase
    m = $signed({1'b0, mag});
    return ph[4] ? -m : m;
  endfunction
endpackage

// File: rtl/dtmf_code_map.sv
module dtmf_code_map
  import dtmf_pkg::*;
(
  input  logic [3:0] code_i,
  output grp_idx_t   row_o,
  output grp_idx_t   col_o
);
  logic [3:0] rc;

  always_comb begin
    case (code_i)
      4'd1:  rc = 4'b00_00;
      4'd2:  rc = 4'b00_01;
      4'd3:  rc = 4'b00_10;
      4'd4:  rc = 4'b01_00;
      4'd5:  rc = 4'b01_01;
      4'd6:  rc = 4'b01_10;
      4'd7:  rc = 4'b10_00;
      4'd8:  rc = 4'b10_01;
      4'd9:  rc = 4'b10_10;
      4'd10: rc = 4'b11_01;
      4'd11: rc = 4'b11_00;
      4'd12: rc = 4'b11_10;
      4'd13: rc = 4'b00_11;
      4'd14: rc = 4'b01_11;
      4'd15: rc = 4'b10_11;
      default: rc = 4'b11_11;
    endcase
  end

  assign row_o = rc[3:2];
  assign col_o = rc[1:0];
endmodule

// File: rtl/dtmf_tone_osc.sv
module dtmf_tone_osc
  import dtmf_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    run_i,
  input  logic [DIV_W-1:0]        seg_len_i,
  output logic signed [SMP_W-1:0] sample_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [PH_W-1:0]  ph_q;
  logic [DIV_W-1:0] last_cnt;

  assign last_cnt = seg_len_i - DIV_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ph_q  <= '0;
    end else if (!run_i) begin
      cnt_q <= '0;
      ph_q  <= '0;
    end else if (cnt_q >= last_cnt) begin
      // >= keeps the count bounded if the code changes mid-tone
      cnt_q <= '0;
      ph_q  <= ph_q + PH_W'(1);
    end else begin
      cnt_q <= cnt_q + DIV_W'(1);
    end
  end

  assign sample_o = sine_at(ph_q);

  p_phase_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(run_i) |-> (ph_q == $past(ph_q) || ph_q == $past(ph_q) + PH_W'(1)));
endmodule

// File: rtl/dtmf_burst_ctrl.sv
module dtmf_burst_ctrl
  import dtmf_pkg::*;
#(
  parameter int TICK_DIV = 3579,
  parameter int BURST_MS = 51
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic tone_en_i,
  input  logic burst_en_i,
  input  logic cp_mode_i,
  output logic wr_ok_o,
  output logic run_o,
  output logic ready_o
);
  localparam int TK_W = $clog2(TICK_DIV + 1);
  localparam int MS_W = $clog2(2 * BURST_MS + 1);

  tx_state_e        st_q;
  logic [TK_W-1:0]  tick_q;
  logic [MS_W-1:0]  ms_q;
  logic [MS_W-1:0]  last_ms;
  logic             tick_end;

  assign last_ms  = cp_mode_i ? MS_W'(2 * BURST_MS - 1) : MS_W'(BURST_MS - 1);
  assign tick_end = (tick_q == TK_W'(TICK_DIV - 1));
  assign wr_ok_o  = wr_i && (!burst_en_i || st_q == ST_IDLE);
  assign run_o    = (st_q == ST_TONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      tick_q  <= '0;
      ms_q    <= '0;
      ready_o <= 1'b0;
    end else if (!tone_en_i) begin
      st_q    <= ST_IDLE;
      tick_q  <= '0;
      ms_q    <= '0;
      ready_o <= 1'b0;
    end else if (!burst_en_i) begin
      st_q    <= ST_TONE;
      tick_q  <= '0;
      ms_q    <= '0;
      ready_o <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (wr_i) begin
          st_q    <= ST_TONE;
          tick_q  <= '0;
          ms_q    <= '0;
          ready_o <= 1'b0;
        end
        default: if (tick_end) begin
          tick_q <= '0;
          if (ms_q >= last_ms) begin
            ms_q <= '0;
            if (st_q == ST_TONE) st_q <= ST_PAUSE;
            else begin
              st_q    <= ST_IDLE;
              ready_o <= 1'b1;
            end
          end else begin
            ms_q <= ms_q + MS_W'(1);
          end
        end else begin
          tick_q <= tick_q + TK_W'(1);
        end
      endcase
    end
  end

  p_ready_src_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> $past(st_q == ST_PAUSE));
  p_nb_ready_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !burst_en_i |=> !ready_o);
  p_tick_bound_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_q < TK_W'(TICK_DIV));
endmodule

// File: rtl/dtmf_burst_gen.sv
module dtmf_burst_gen
  import dtmf_pkg::*;
#(
  parameter int CLK_HZ   = 3579545,
  parameter int TICK_DIV = CLK_HZ / 1000,
  parameter int BURST_MS = 51
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [3:0]       code_i,
  input  logic             tone_en_i,
  input  logic             burst_en_i,
  input  logic             cp_mode_i,
  input  logic             single_i,
  input  logic             col_sel_i,
  output logic [OUT_W-1:0] sample_o,
  output logic             ready_o
);
  localparam int MAX_DIV = seg_len(CLK_HZ, ROW_HZ[0]);
  localparam int DIV_W   = $clog2(MAX_DIV + 1);

  logic [3:0] code_q;
  logic       wr_ok, run;
  grp_idx_t   row_idx, col_idx;

  logic [DIV_W-1:0]        div_tab [8];
  logic [2:0]              sel     [2];
  logic signed [SMP_W-1:0] smp     [2];

  logic signed [OUT_W-1:0] row_x, col_b, col_x, mix;
  logic signed [OUT_W-1:0] sample_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    code_q <= '0;
    else if (wr_ok) code_q <= code_i;
  end

  dtmf_burst_ctrl #(.TICK_DIV(TICK_DIV), .BURST_MS(BURST_MS)) u_ctrl (
    .clk_i, .rst_ni, .wr_i, .tone_en_i, .burst_en_i, .cp_mode_i,
    .wr_ok_o(wr_ok), .run_o(run), .ready_o
  );

  dtmf_code_map u_map (.code_i(code_q), .row_o(row_idx), .col_o(col_idx));

  for (genvar g = 0; g < 4; g++) begin : g_tab
    assign div_tab[g]     = DIV_W'(seg_len(CLK_HZ, ROW_HZ[g]));
    assign div_tab[g + 4] = DIV_W'(seg_len(CLK_HZ, COL_HZ[g]));
  end

  assign sel[0] = {1'b0, row_idx};
  assign sel[1] = {1'b1, col_idx};

  for (genvar g = 0; g < 2; g++) begin : g_osc
    dtmf_tone_osc #(.DIV_W(DIV_W)) u_osc (
      .clk_i, .rst_ni, .run_i(run),
      .seg_len_i(div_tab[sel[g]]),
      .sample_o(smp[g])
    );
  end

  // column emphasis x1.25 (~2 dB)
  always_comb begin
    row_x = $signed({{(OUT_W-SMP_W){smp[0][SMP_W-1]}}, smp[0]});
    col_b = $signed({{(OUT_W-SMP_W){smp[1][SMP_W-1]}}, smp[1]});
    col_x = col_b + (col_b >>> 2);
    if (single_i) mix = col_sel_i ? col_x : row_x;
    else          mix = row_x + col_x;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sample_q <= '0;
    else         sample_q <= run ? mix : '0;
  end

  assign sample_o = sample_q;

  p_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_q <= 10'sd286) && (sample_q >= -10'sd286));
  p_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !wr_ok) |=> $stable(code_q));
  p_silent_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(!tone_en_i, 2) && $past(!tone_en_i)) |-> (sample_q == '0));
endmodule

// File: tb/dtmf_burst_gen_tb_top.sv
`timescale 1ns/1ps
module dtmf_burst_gen_tb_top;
  localparam int CLK_HZ   = 1_000_000;
  localparam int TICK     = CLK_HZ / 1000;
  localparam int BURST_MS = 3;
  localparam int N        = BURST_MS * TICK;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       wr = 0, tone_en = 0, burst_en = 0, cp = 0, single = 0, colsel = 0;
  logic [3:0] code = '0;
  logic [9:0] sample;
  logic       ready;

  dtmf_burst_gen #(.CLK_HZ(CLK_HZ), .BURST_MS(BURST_MS)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .code_i(code), .tone_en_i(tone_en),
    .burst_en_i(burst_en), .cp_mode_i(cp), .single_i(single), .col_sel_i(colsel),
    .sample_o(sample), .ready_o(ready)
  );

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 0;
  int row_hz [4] = '{697, 770, 852, 941};
  int col_hz [4] = '{1209, 1336, 1477, 1633};

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int sval();
    return int'($signed(sample));
  endfunction

  function automatic int exp_div(input int f);
    return $rtoi(real'(CLK_HZ) / (32.0 * f) + 0.5);
  endfunction

  function automatic int exp_sin(input int p);
    real x;
    x = 127.0 * $sin(2.0 * 3.141592653589793 * p / 32.0);
    return (x >= 0.0) ? $rtoi(x + 0.5) : -$rtoi(-x + 0.5);
  endfunction

  function automatic int floor4(input int v);
    return (v >= 0) ? v / 4 : -((-v + 3) / 4);
  endfunction

  function automatic void map_code(input int c, output int r, output int k);
    if (c >= 1 && c <= 9) begin r = (c - 1) / 3; k = (c - 1) % 3; end
    else if (c == 10) begin r = 3; k = 1; end
    else if (c == 11) begin r = 3; k = 0; end
    else if (c == 12) begin r = 3; k = 2; end
    else if (c >= 13) begin r = c - 13; k = 3; end
    else begin r = 3; k = 3; end
  endfunction

  function automatic int exp_val(input int c, input int k, input bit sg, input bit cs);
    int r, q, rs, cv, cx;
    map_code(c, r, q);
    rs = exp_sin(((k - 1) / exp_div(row_hz[r])) % 32);
    cv = exp_sin(((k - 1) / exp_div(col_hz[q])) % 32);
    cx = cv + floor4(cv);
    if (sg) return cs ? cx : rs;
    return rs + cx;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      finish_run();
    end
  end

  // continuous tone: R1 R2 R3 R4 R5 R6 R7 R8
  task automatic run_tone(input int c, input bit sg, input bit cs, input int len);
    @(negedge clk);
    tone_en = 0; burst_en = 0; single = sg; colsel = cs; code = 4'(c); wr = 1;
    @(negedge clk);
    wr = 0; tone_en = 1;
    @(negedge clk);
    for (int k = 1; k <= len; k++) begin
      @(negedge clk);
      chk($sformatf("R1 R2 R3 R4 R5 R6 code=%0d k=%0d", c, k), sval(), exp_val(c, k, sg, cs));
    end
    chk("R8 ready low in continuous mode", int'(ready), 0);
    tone_en = 0;
    @(negedge clk);
    @(negedge clk);
    chk("R7 silent after disable", sval(), 0);
  endtask

  // burst: R9 R10 R11 R12
  task automatic run_burst(input int c, input bit cpm, input bit probe);
    int len;
    len = cpm ? 2 * N : N;
    @(negedge clk);
    tone_en = 1; burst_en = 1; cp = cpm; single = 0; code = 4'(c); wr = 1;
    @(negedge clk);
    wr = 0;
    chk("R11 ready cleared by write", int'(ready), 0);
    for (int k = 1; k <= 2 * len; k++) begin
      if (probe && k == 100) begin wr = 1; code = 4'd3; end
      if (probe && k == 101) wr = 0;
      @(negedge clk);
      if (k <= len)
        chk($sformatf("R9 R10 R12 burst code=%0d k=%0d", c, k), sval(), exp_val(c, k, 0, 0));
      else if (k >= len + 2)
        chk($sformatf("R9 R10 pause k=%0d", k), sval(), 0);
      if (k == 2 * len - 1) chk("R11 ready before pause end", int'(ready), 0);
      if (k == 2 * len)     chk("R11 ready at pause end", int'(ready), 1);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R13 sample in reset", sval(), 0);
    chk("R13 ready in reset", int'(ready), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R13 sample after reset", sval(), 0);
    chk("R13 ready after reset", int'(ready), 0);

    for (int c = 0; c < 16; c++) run_tone(c, 0, 0, 1500);
    run_tone(5, 1, 1, 800);
    run_tone(5, 1, 0, 1500);
    run_tone(13, 1, 1, 700);

    run_burst(7, 0, 1);
    run_burst(0, 1, 0);

    @(negedge clk);
    tone_en = 0;
    @(negedge clk);
    chk("R7 ready cleared by disable", int'(ready), 0);
    finish_run();
  end
endmodule